// File: doc/BRIEF.md
# Card Clock Divider

This block derives a card clock from the master clock of a storage-card host controller. A single control word carries an 8-bit divide value, an enable bit and a bypass bit. In divide mode the card clock runs at the master rate divided by twice (divide + 1), with equal high and low phases. In bypass mode every master cycle is a whole card-clock cycle. With enable clear the card clock is parked low and silent.

The card clock leaves the block in three forms, all in the master domain: a level, a clock-enable that is high in the master cycle ending in a rising card edge, and one-cycle strobes that mark the rising and falling edges for the command and data paths. A new control word is held pending. It replaces the running setting only at the end of a low phase, or at once when the clock is idle or in bypass, so a setting change never cuts a phase short.

Top module: `sdclk_divider`

## Requirements
- R1: After reset, card_lvl_o, card_ce_o, rise_stb_o and fall_stb_o are all 0 and remain 0 until a control word is written.
- R2: With enable 1 and bypass 0, the card-clock level repeats every 2*(D+1) master cycles, high for D+1 cycles and low for D+1 cycles, where D is the divide value.
- R3: Every divide value from 0 to 255 is accepted; D=255 gives a 512-cycle period and D=0 a 2-cycle period.
- R4: With enable 1 and bypass 1, card_ce_o, rise_stb_o and fall_stb_o are 1 in every master cycle and card_lvl_o is 0.
- R5: With enable 0, card_lvl_o, card_ce_o and both strobes stay 0 whatever the bypass bit and divide value hold.
- R6: Writing an all-zero control word (divide 0, enable 0, bypass 0) to a running clock stops it within one period, leaving it low and silent.
- R7: A written word takes effect at the master edge that would end the current low phase, or at the next edge when the clock is idle or in bypass; that edge produces no rising edge, and a low phase of D_new+1 cycles follows before the first rise under the new setting.
- R8: rise_stb_o is 1 for exactly the first master cycle of each high phase and fall_stb_o for exactly the first master cycle of each low phase (both in every cycle in bypass).
- R9: card_ce_o is 1 in the master cycle immediately before each cycle in which rise_stb_o is 1, and 0 in every other cycle.
- R10: A second write made before the first has taken effect replaces the pending word; only the most recent word is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_i | input | 1 | Control-word write strobe, one master cycle |
| cfg_div_i | input | DIV_W (8) | Divide value D |
| cfg_en_i | input | 1 | Card-clock enable |
| cfg_bypass_i | input | 1 | Pass master rate through undivided |
| card_ce_o | output | 1 | Clock-enable, high in the cycle that ends in a rising card edge |
| card_lvl_o | output | 1 | Card-clock level |
| rise_stb_o | output | 1 | Strobe in the first cycle of a high phase |
| fall_stb_o | output | 1 | Strobe in the first cycle of a low phase |

## Verification
The assertions take for granted that the control inputs are only sampled when the write strobe is high and that a written setting never alters a phase already in progress, so the high-phase length they check is always tied to the setting that was active when the phase began. They also assume that no write arrives while the internal reset is still being released. The stimulus holds the control fields steady around each one-cycle write strobe, waits several cycles after reset before its first write, and places writes deliberately mid-high-phase and back to back so that the deferred and replaced paths are both taken.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_DIV  = 2'd1,
    MODE_THRU = 2'd2
  } ccd_mode_e;

  function automatic ccd_mode_e ccd_mode_of(input logic en, input logic bypass);
    if (!en)        return MODE_IDLE;
    else if (bypass) return MODE_THRU;
    else            return MODE_DIV;
  endfunction

endpackage

// File: rtl/ccd_rst_sync.sv
module ccd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/ccd_cfg_stage.sv
module ccd_cfg_stage
  import ccd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             en_i,
  input  logic             bypass_i,
  input  logic             boundary_i,
  output logic             pend_vld_o,
  output logic             apply_o,
  output logic [DIV_W-1:0] act_div_o,
  output ccd_mode_e        act_mode_o
);

  logic [DIV_W-1:0] pend_div_q;
  ccd_mode_e        pend_mode_q;
  logic             pend_vld_q, pend_vld_d;
  logic [DIV_W-1:0] act_div_q;
  ccd_mode_e        act_mode_q;
  logic             apply;

  assign apply = pend_vld_q && boundary_i;

  always_comb begin
    pend_vld_d = pend_vld_q;
    if (wr_i)       pend_vld_d = 1'b1;
    else if (apply) pend_vld_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_vld_q <= 1'b0;
    else         pend_vld_q <= pend_vld_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_div_q  <= '0;
      pend_mode_q <= MODE_IDLE;
    end else if (wr_i) begin
      pend_div_q  <= div_i;
      pend_mode_q <= ccd_mode_of(en_i, bypass_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_q  <= '0;
      act_mode_q <= MODE_IDLE;
    end else if (apply) begin
      act_div_q  <= pend_div_q;
      act_mode_q <= pend_mode_q;
    end
  end

  assign pend_vld_o = pend_vld_q;
  assign apply_o    = apply;
  assign act_div_o  = act_div_q;
  assign act_mode_o = act_mode_q;

endmodule

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen
  import ccd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  ccd_mode_e        mode_i,
  input  logic             apply_i,
  input  logic             pend_vld_i,
  output logic             boundary_o,
  output logic             ce_o,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;
  logic             at_end;
  logic             upd_en;

  assign at_end = (cnt_q == div_i);

  // Low-phase end in divide mode, or any cycle outside divide mode.
  assign boundary_o = (mode_i != MODE_DIV) || (!lvl_q && at_end);

  assign ce_o = !pend_vld_i &&
                ((mode_i == MODE_THRU) || (mode_i == MODE_DIV && !lvl_q && at_end));

  assign upd_en = apply_i || (mode_i != MODE_IDLE);

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (apply_i) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else begin
      unique case (mode_i)
        MODE_THRU: begin
          cnt_d  = '0;
          lvl_d  = 1'b0;
          rise_d = 1'b1;
          fall_d = 1'b1;
        end
        MODE_DIV: begin
          if (at_end) begin
            cnt_d  = '0;
            lvl_d  = ~lvl_q;
            rise_d = ~lvl_q;
            fall_d = lvl_q;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          cnt_d = '0;
          lvl_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import ccd_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RST_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_en_i,
  input  logic             cfg_bypass_i,
  output logic             card_ce_o,
  output logic             card_lvl_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);

  logic             rst_sync_n;
  logic             pend_vld;
  logic             apply;
  logic             boundary;
  logic [DIV_W-1:0] act_div;
  ccd_mode_e        act_mode;

  ccd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ccd_cfg_stage #(.DIV_W(DIV_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .wr_i       (cfg_wr_i),
    .div_i      (cfg_div_i),
    .en_i       (cfg_en_i),
    .bypass_i   (cfg_bypass_i),
    .boundary_i (boundary),
    .pend_vld_o (pend_vld),
    .apply_o    (apply),
    .act_div_o  (act_div),
    .act_mode_o (act_mode)
  );

  ccd_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .div_i      (act_div),
    .mode_i     (act_mode),
    .apply_i    (apply),
    .pend_vld_i (pend_vld),
    .boundary_o (boundary),
    .ce_o       (card_ce_o),
    .lvl_o      (card_lvl_o),
    .rise_o     (rise_stb_o),
    .fall_o     (fall_stb_o)
  );

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk
  import ccd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             card_ce,
  input logic             card_lvl,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic [DIV_W-1:0] act_div,
  input ccd_mode_e        act_mode
);

  logic [DIV_W:0] hi_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_run_q <= '0;
    else if (card_lvl) hi_run_q <= hi_run_q + 1'b1;
    else               hi_run_q <= '0;
  end

  // R2: each high phase lasts D+1 master cycles
  p_high_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_lvl) |-> (hi_run_q == ({1'b0, act_div} + 1'b1)));

  // R8: level rises only together with the rise strobe
  p_rise_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_lvl) |-> rise_stb);

  // R8: level falls only together with the fall strobe
  p_fall_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_lvl) |-> fall_stb);

  // R9: clock-enable is followed by a rise strobe
  p_ce_then_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_ce |=> rise_stb);

  // R5: idle setting keeps every output quiet
  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode == MODE_IDLE) |-> (!card_lvl && !rise_stb && !fall_stb && !card_ce));

endmodule

bind sdclk_divider sdclk_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_sync_n),
  .card_ce  (card_ce_o),
  .card_lvl (card_lvl_o),
  .rise_stb (rise_stb_o),
  .fall_stb (fall_stb_o),
  .act_div  (act_div),
  .act_mode (act_mode)
);

// File: tb/sdclk_divider_tb_top.sv
`timescale 1ns/1ps
module sdclk_divider_tb_top;

  localparam int DIV_W = 8;

  logic             clk;
  logic             rst_n;
  logic             wr;
  logic [DIV_W-1:0] div;
  logic             en;
  logic             byp;
  logic             ce, lvl, rise, fall;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sdclk_divider #(.DIV_W(DIV_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_wr_i     (wr),
    .cfg_div_i    (div),
    .cfg_en_i     (en),
    .cfg_bypass_i (byp),
    .card_ce_o    (ce),
    .card_lvl_o   (lvl),
    .rise_stb_o   (rise),
    .fall_stb_o   (fall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: a queue of pending words, phase bookkeeping by integers
  int  m_div, m_tick;
  bit  m_en, m_byp, m_hi, m_rise, m_fall;
  int  q_div[$];
  bit  q_en[$], q_byp[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_tick = 0; m_en = 0; m_byp = 0; m_hi = 0;
      m_rise = 0; m_fall = 0;
      q_div.delete(); q_en.delete(); q_byp.delete();
    end else begin
      bit may_swap, swap;
      may_swap = !m_en || m_byp || (!m_hi && m_tick == m_div);
      swap = (q_div.size() > 0) && may_swap;
      m_rise = 0; m_fall = 0;
      if (swap) begin
        m_div = q_div[0]; m_en = q_en[0]; m_byp = q_byp[0];
        m_tick = 0; m_hi = 0;
      end else if (m_en && m_byp) begin
        m_rise = 1; m_fall = 1;
      end else if (m_en) begin
        if (m_tick == m_div) begin
          m_hi = !m_hi; m_rise = m_hi; m_fall = !m_hi; m_tick = 0;
        end else m_tick++;
      end
      if (wr) begin
        q_div.delete(); q_en.delete(); q_byp.delete();
        q_div.push_back(int'(div)); q_en.push_back(en); q_byp.push_back(byp);
      end else if (swap) begin
        q_div.delete(); q_en.delete(); q_byp.delete();
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_ce;
      cyc++;
      exp_ce = m_en && (q_div.size() == 0) &&
               (m_byp || (!m_hi && m_tick == m_div));
      chk("R2 level",       int'(lvl),  int'(m_hi));
      chk("R8 rise strobe", int'(rise), int'(m_rise));
      chk("R8 fall strobe", int'(fall), int'(m_fall));
      chk("R9 clock enable", int'(ce),  int'(exp_ce));
    end
  end

  task automatic write_cfg(input int d, input bit e, input bit b);
    div = DIV_W'(d); en = e; byp = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_rise();
    int guard = 0;
    while (!rise && guard < 2000) begin @(negedge clk); guard++; end
    if (!rise) chk("R2 rise seen", 0, 1);
  endtask

  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    wait_rise();
    do begin
      if (lvl) hi++;
      per++;
      @(negedge clk);
    end while (!rise && per < 2000);
  endtask

  task automatic measure_cfg(input string tag, input int d);
    int per, hi;
    write_cfg(d, 1'b1, 1'b0);
    measure(per, hi);
    measure(per, hi);
    chk({tag, " period"}, per, 2 * (d + 1));
    chk({tag, " high"},   hi,  d + 1);
  endtask

  initial begin
    int per, hi, lo, guard;
    bit quiet;
    rst_n = 1'b0; wr = 1'b0; div = '0; en = 1'b0; byp = 1'b0;
    repeat (5) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 lvl in reset",  int'(lvl),  0);
    chk("R1 ce in reset",   int'(ce),   0);
    chk("R1 rise in reset", int'(rise), 0);
    chk("R1 fall in reset", int'(fall), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 quiet after reset", int'(lvl | ce | rise | fall), 0);

    measure_cfg("R2 d0", 0);
    measure_cfg("R2 d3", 3);
    measure_cfg("R3 d255", 255);

    // R4: bypass
    write_cfg(4, 1'b1, 1'b1);
    repeat (600) @(negedge clk);
    quiet = 1;
    for (int i = 0; i < 10; i++) begin
      if (!(ce && rise && fall && !lvl)) quiet = 0;
      @(negedge clk);
    end
    chk("R4 bypass pattern", int'(quiet), 1);

    // R5: enable clear with bypass set
    write_cfg(5, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      if (lvl || ce || rise || fall) quiet = 0;
      @(negedge clk);
    end
    chk("R5 disabled quiet", int'(quiet), 1);

    // R6: all-zero word stops a running clock
    write_cfg(7, 1'b1, 1'b0);
    wait_rise();
    write_cfg(0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      if (lvl || ce || rise || fall) quiet = 0;
      @(negedge clk);
    end
    chk("R6 stopped by zero word", int'(quiet), 1);

    // R7: write mid-high-phase is deferred to the low-phase end
    write_cfg(9, 1'b1, 1'b0);
    wait_rise();
    hi = 1;
    write_cfg(1, 1'b1, 1'b0);
    guard = 0;
    while (lvl && guard < 100) begin hi++; @(negedge clk); guard++; end
    lo = 0;
    while (!rise && lo < 100) begin lo++; @(negedge clk); end
    chk("R7 old high phase kept", hi, 10);
    chk("R7 old low plus new low", lo, 12);
    measure(per, hi);
    chk("R7 new period", per, 4);

    // R10: second write replaces the pending one
    write_cfg(9, 1'b1, 1'b0);
    wait_rise();
    write_cfg(2, 1'b1, 1'b0);
    write_cfg(4, 1'b1, 1'b0);
    measure(per, hi);
    measure(per, hi);
    chk("R10 latest word period", per, 10);
    chk("R10 latest word high", hi, 5);

    repeat (5) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule